// File: doc/BRIEF.md
# Linked Auto-Reload DMA Channel

This block is one DMA channel. Software loads six 32-bit parameter words and then pulses a start strobe. The channel copies a counted block of 16-bit elements from a source address to a destination address. Each element is read in one cycle and written in the next. After each element the count goes down by one and both addresses go up by one. When the count runs out, the channel raises a one-cycle completion pulse that carries the options word of the finished transfer.

If the options word enables linking, the completion also starts a reload. The channel reads six consecutive words from a small parameter RAM, starting at the link address held in its own last parameter word, and these words replace the whole active parameter set. A set that links to itself therefore rebuilds the same transfer after every completion. After the reload the channel stays idle until the next start strobe.

Top module: `dma_chan`

## Requirements
- R1: After synchronous reset the channel is idle. `busy_o`, `done_o`, `mem_rd_en_o`, `mem_wr_en_o` and `prm_rd_en_o` are all low.
- R2: Element k (counting from 0) of a started transfer works as follows:
  - The read strobe is high with address source+k in cycle 2k+1 after the start cycle.
  - The write strobe is high with address destination+k in cycle 2k+2.
  - The data written is the memory data returned for that read, one cycle after the read strobe.
- R3: A transfer moves exactly count elements and writes no other location. Afterwards the count word is zero and source and destination have each advanced by count. A later start therefore continues from the advanced addresses.
- R4: For a transfer of N elements, `done_o` is high for exactly cycle 2N+1 after the start cycle. In that cycle `done_opt_o` equals the options word of that transfer. `busy_o` is high from cycle 1 through cycle 2N.
- R5: Linking is enabled when options bit 1 is set and the link address (bits 15:0 of word 5) is not 16'hFFFF. In that case:
  - In cycles 2N+1 to 2N+6 the channel reads parameter RAM addresses link+0 to link+5, one per cycle.
  - These words load the active set in the order options, source, count, destination, index, reload/link.
  - `busy_o` stays high until cycle 2N+7 and is low from cycle 2N+8.
- R6: When options bit 1 is clear, or the link address is 16'hFFFF, no parameter RAM read occurs and `busy_o` is low from cycle 2N+1.
- R7: A reload set whose link address points at itself restores the same parameters after every completion. Repeated starts then produce identical transfers.
- R8: A start strobe and configuration writes that arrive while `busy_o` is high are ignored.
- R9: A start with a count of zero moves no element. It raises `done_o` in cycle 1 and then reloads as in R5 if linking is enabled.
- R10: After completion or reload the channel issues no memory or parameter RAM access until a new start strobe.
- R11: A configuration write while idle loads word `cfg_sel_i` of the active set. The select codes are: 0 options, 1 source, 2 count, 3 destination, 4 index, 5 reload/link (bits 31:16 count reload, bits 15:0 link address).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| cfg_we_i | input | 1 | Parameter word write enable |
| cfg_sel_i | input | 3 | Selects which parameter word is written |
| cfg_wdata_i | input | 32 | Parameter word write data |
| mem_rd_en_o | output | 1 | Element read strobe |
| mem_rd_addr_o | output | 32 | Element read address |
| mem_rd_data_i | input | 16 | Element read data, valid one cycle after the read strobe |
| mem_wr_en_o | output | 1 | Element write strobe |
| mem_wr_addr_o | output | 32 | Element write address |
| mem_wr_data_o | output | 16 | Element write data |
| prm_rd_en_o | output | 1 | Parameter RAM read strobe |
| prm_addr_o | output | 16 | Parameter RAM word address |
| prm_rd_data_i | input | 32 | Parameter RAM data, valid one cycle after the strobe |
| done_o | output | 1 | One-cycle completion pulse |
| done_opt_o | output | 32 | Options word of the completed transfer |
| busy_o | output | 1 | Channel is moving data or reloading |

## Verification
Counting from the cycle in which the start strobe is sampled:
- The read for element k is due in cycle 2k+1 and its write in cycle 2k+2.
- The completion pulse is due in cycle 2N+1.
- The six parameter RAM reads are due in cycles 2N+1 to 2N+6.
- `busy_o` falls at 2N+1 without a reload and at 2N+8 with one.

For every cycle of a transfer, the bench computes from these indices which strobes, addresses and data must appear. It samples them at the falling edge of that same cycle. After each run it checks destination memory and the state carried forward (advanced addresses, zero count or reloaded set) by issuing the next start.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int unsigned PWORD_W   = 32;
    localparam int unsigned SET_WORDS = 6;
    localparam int unsigned SEL_W     = 3;
    localparam int unsigned LINK_W    = 16;
    localparam logic [LINK_W-1:0] NO_LINK = '1;

    typedef enum logic [SEL_W-1:0] {
        PW_OPT = 3'd0,
        PW_SRC = 3'd1,
        PW_CNT = 3'd2,
        PW_DST = 3'd3,
        PW_IDX = 3'd4,
        PW_RLK = 3'd5
    } pword_e;

    typedef struct packed {
        logic [PWORD_W-1:0] opt;
        logic [PWORD_W-1:0] src;
        logic [PWORD_W-1:0] cnt;
        logic [PWORD_W-1:0] dst;
        logic [PWORD_W-1:0] idx;
        logic [PWORD_W-1:0] rlk;
    } pset_t;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_READ,
        CH_WRITE,
        CH_RELOAD
    } ch_state_e;

    function automatic logic [LINK_W-1:0] link_addr(input logic [PWORD_W-1:0] rlk);
        return rlk[LINK_W-1:0];
    endfunction

    function automatic logic reload_wanted(input logic [PWORD_W-1:0] opt,
                                           input logic [PWORD_W-1:0] rlk,
                                           input int unsigned        link_bit);
        return opt[link_bit] && (link_addr(rlk) != NO_LINK);
    endfunction

    function automatic pset_t put_word(input pset_t              s,
                                       input logic [SEL_W-1:0]   sel,
                                       input logic [PWORD_W-1:0] d);
        pset_t r;
        r = s;
        case (pword_e'(sel))
            PW_OPT:  r.opt = d;
            PW_SRC:  r.src = d;
            PW_CNT:  r.cnt = d;
            PW_DST:  r.dst = d;
            PW_IDX:  r.idx = d;
            PW_RLK:  r.rlk = d;
            default: r = s;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dma_param_regs.sv
module dma_param_regs
    import dma_chan_pkg::*;
#(
    parameter int unsigned ELEM_STEP = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we_i,
    input  logic [SEL_W-1:0]   cfg_sel_i,
    input  logic [PWORD_W-1:0] cfg_wdata_i,
    input  logic               step_i,
    input  logic               ld_we_i,
    input  logic [SEL_W-1:0]   ld_sel_i,
    input  logic [PWORD_W-1:0] ld_data_i,
    output pset_t              prm_o
);

    pset_t prm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prm_q <= '0;
        end else if (ld_we_i) begin
            prm_q <= put_word(prm_q, ld_sel_i, ld_data_i);
        end else if (step_i) begin
            prm_q.cnt <= prm_q.cnt - PWORD_W'(1);
            prm_q.src <= prm_q.src + PWORD_W'(ELEM_STEP);
            prm_q.dst <= prm_q.dst + PWORD_W'(ELEM_STEP);
        end else if (cfg_we_i) begin
            prm_q <= put_word(prm_q, cfg_sel_i, cfg_wdata_i);
        end
    end

    assign prm_o = prm_q;

endmodule

// File: rtl/dma_reload_seq.sv
module dma_reload_seq
    import dma_chan_pkg::*;
#(
    parameter int unsigned PADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go_i,
    input  logic [LINK_W-1:0]  base_i,
    output logic               rd_en_o,
    output logic [PADDR_W-1:0] rd_addr_o,
    output logic               wr_en_o,
    output logic [SEL_W-1:0]   wr_sel_o,
    output logic               last_o
);

    localparam int unsigned K_W = $clog2(SET_WORDS + 1);
    localparam logic [K_W-1:0] K_END = K_W'(SET_WORDS);

    logic               active_q;
    logic [K_W-1:0]     k_q;
    logic [PADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            k_q      <= '0;
            base_q   <= '0;
        end else if (go_i) begin
            active_q <= 1'b1;
            k_q      <= '0;
            base_q   <= PADDR_W'(base_i);
        end else if (active_q) begin
            if (k_q == K_END) begin
                active_q <= 1'b0;
            end else begin
                k_q <= k_q + K_W'(1);
            end
        end
    end

    // one read issued per step, data lands one step later
    assign rd_en_o   = active_q && (k_q < K_END);
    assign rd_addr_o = base_q + PADDR_W'(k_q);
    assign wr_en_o   = active_q && (k_q != '0);
    assign wr_sel_o  = SEL_W'(k_q - K_W'(1));
    assign last_o    = active_q && (k_q == K_END);

    // R5
    prm_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == $past(rd_addr_o) + PADDR_W'(1)));

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
    import dma_chan_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [PWORD_W-1:0] opt_i,
    input  logic [PWORD_W-1:0] cnt_i,
    input  logic               reload_en_i,
    input  logic               rld_last_i,
    output logic               rd_en_o,
    output logic               wr_en_o,
    output logic               step_o,
    output logic               rld_go_o,
    output logic               busy_o,
    output logic               cfg_ok_o,
    output logic               done_o,
    output logic [PWORD_W-1:0] done_opt_o
);

    ch_state_e          state_q, state_d;
    logic               finish;
    logic               done_q;
    logic [PWORD_W-1:0] done_opt_q;

    always_comb begin
        state_d  = state_q;
        rd_en_o  = 1'b0;
        wr_en_o  = 1'b0;
        step_o   = 1'b0;
        finish   = 1'b0;
        rld_go_o = 1'b0;
        case (state_q)
            CH_IDLE: begin
                if (start_i) begin
                    if (cnt_i == '0) finish = 1'b1;
                    else             state_d = CH_READ;
                end
            end
            CH_READ: begin
                rd_en_o = 1'b1;
                state_d = CH_WRITE;
            end
            CH_WRITE: begin
                wr_en_o = 1'b1;
                step_o  = 1'b1;
                if (cnt_i == PWORD_W'(1)) finish = 1'b1;
                else                      state_d = CH_READ;
            end
            CH_RELOAD: begin
                if (rld_last_i) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
        if (finish) begin
            if (reload_en_i) begin
                rld_go_o = 1'b1;
                state_d  = CH_RELOAD;
            end else begin
                state_d  = CH_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= CH_IDLE;
            done_q     <= 1'b0;
            done_opt_q <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            if (finish) done_opt_q <= opt_i;
        end
    end

    assign busy_o     = (state_q != CH_IDLE);
    assign cfg_ok_o   = (state_q == CH_IDLE);
    assign done_o     = done_q;
    assign done_opt_o = done_opt_q;

    // R2
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> $past(rd_en_o));

    // R10
    idle_until_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_READ && $past(state_q) != CH_WRITE) |-> $past(start_i));

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned MADDR_W   = 32,
    parameter int unsigned PADDR_W   = 16,
    parameter int unsigned LINK_BIT  = 1,
    parameter int unsigned ELEM_STEP = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               cfg_we_i,
    input  logic [SEL_W-1:0]   cfg_sel_i,
    input  logic [PWORD_W-1:0] cfg_wdata_i,
    output logic               mem_rd_en_o,
    output logic [MADDR_W-1:0] mem_rd_addr_o,
    input  logic [DATA_W-1:0]  mem_rd_data_i,
    output logic               mem_wr_en_o,
    output logic [MADDR_W-1:0] mem_wr_addr_o,
    output logic [DATA_W-1:0]  mem_wr_data_o,
    output logic               prm_rd_en_o,
    output logic [PADDR_W-1:0] prm_addr_o,
    input  logic [PWORD_W-1:0] prm_rd_data_i,
    output logic               done_o,
    output logic [PWORD_W-1:0] done_opt_o,
    output logic               busy_o
);

    pset_t            prm;
    logic             step, cfg_ok, rld_go, rld_last, ld_we;
    logic [SEL_W-1:0] ld_sel;
    logic             reload_en;
    logic             unused_bits;

    assign reload_en   = reload_wanted(prm.opt, prm.rlk, LINK_BIT);
    assign unused_bits = ^{prm.idx, prm.rlk[PWORD_W-1:LINK_W]};

    dma_param_regs #(.ELEM_STEP(ELEM_STEP)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .cfg_we_i    (cfg_we_i && cfg_ok),
        .cfg_sel_i   (cfg_sel_i),
        .cfg_wdata_i (cfg_wdata_i),
        .step_i      (step),
        .ld_we_i     (ld_we),
        .ld_sel_i    (ld_sel),
        .ld_data_i   (prm_rd_data_i),
        .prm_o       (prm)
    );

    dma_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .opt_i       (prm.opt),
        .cnt_i       (prm.cnt),
        .reload_en_i (reload_en),
        .rld_last_i  (rld_last),
        .rd_en_o     (mem_rd_en_o),
        .wr_en_o     (mem_wr_en_o),
        .step_o      (step),
        .rld_go_o    (rld_go),
        .busy_o      (busy_o),
        .cfg_ok_o    (cfg_ok),
        .done_o      (done_o),
        .done_opt_o  (done_opt_o)
    );

    dma_reload_seq #(.PADDR_W(PADDR_W)) u_rld (
        .clk       (clk),
        .rst       (rst),
        .go_i      (rld_go),
        .base_i    (link_addr(prm.rlk)),
        .rd_en_o   (prm_rd_en_o),
        .rd_addr_o (prm_addr_o),
        .wr_en_o   (ld_we),
        .wr_sel_o  (ld_sel),
        .last_o    (rld_last)
    );

    assign mem_rd_addr_o = prm.src[MADDR_W-1:0];
    assign mem_wr_addr_o = prm.dst[MADDR_W-1:0];
    assign mem_wr_data_o = mem_rd_data_i;

    // R5
    reload_busy_chk: assert property (@(posedge clk) disable iff (rst)
        prm_rd_en_o |-> busy_o);

    // R10
    no_mixed_access_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en_o || mem_wr_en_o) |-> !prm_rd_en_o);

    // R4
    done_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(mem_wr_en_o) || $past(start_i && !busy_o)));

    // R2
    src_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en_o && $past(mem_wr_en_o)) |->
        (mem_rd_addr_o == $past(mem_rd_addr_o, 2) + MADDR_W'(ELEM_STEP)));

endmodule

// File: tb/dma_chan_tb.sv
module dma_chan_tb;
    import dma_chan_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i, cfg_we_i;
    logic [2:0]  cfg_sel_i;
    logic [31:0] cfg_wdata_i;
    logic        mem_rd_en_o, mem_wr_en_o, prm_rd_en_o, done_o, busy_o;
    logic [31:0] mem_rd_addr_o, mem_wr_addr_o, done_opt_o;
    logic [15:0] mem_rd_data_i, mem_wr_data_o, prm_addr_o;
    logic [31:0] prm_rd_data_i;

    always #4 clk = ~clk;

    dma_chan u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .cfg_we_i(cfg_we_i),
        .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
        .mem_rd_en_o(mem_rd_en_o), .mem_rd_addr_o(mem_rd_addr_o),
        .mem_rd_data_i(mem_rd_data_i), .mem_wr_en_o(mem_wr_en_o),
        .mem_wr_addr_o(mem_wr_addr_o), .mem_wr_data_o(mem_wr_data_o),
        .prm_rd_en_o(prm_rd_en_o), .prm_addr_o(prm_addr_o),
        .prm_rd_data_i(prm_rd_data_i), .done_o(done_o),
        .done_opt_o(done_opt_o), .busy_o(busy_o)
    );

    logic [15:0] dmem [0:255];
    logic [31:0] pram [0:63];

    always @(posedge clk) begin
        if (mem_rd_en_o) mem_rd_data_i <= dmem[mem_rd_addr_o[7:0]];
        if (mem_wr_en_o) dmem[mem_wr_addr_o[7:0]] <= mem_wr_data_o;
        if (prm_rd_en_o) prm_rd_data_i <= pram[prm_addr_o[5:0]];
    end

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] m_opt, m_src, m_cnt, m_dst, m_idx, m_rlk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic bit takes_reload(input logic [31:0] o, input logic [31:0] r);
        return o[1] && (r[15:0] != 16'hFFFF);
    endfunction

    task automatic cfg(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic cfg_all(input logic [31:0] o, s, c, d, i, r);
        cfg(3'd0, o); cfg(3'd1, s); cfg(3'd2, c);
        cfg(3'd3, d); cfg(3'd4, i); cfg(3'd5, r);
        m_opt = o; m_src = s; m_cnt = c; m_dst = d; m_idx = i; m_rlk = r;
    endtask

    task automatic put_set(input int base, input logic [31:0] o, s, c, d, i, r);
        pram[base] = o; pram[base+1] = s; pram[base+2] = c;
        pram[base+3] = d; pram[base+4] = i; pram[base+5] = r;
    endtask

    // one started transfer, checked cycle by cycle against the model set
    task automatic run(input bit poke);
        int          n, last;
        bit          rl;
        logic [15:0] lnk, sent;
        logic [15:0] snap [0:15];
        n    = int'(m_cnt);
        rl   = takes_reload(m_opt, m_rlk);
        lnk  = m_rlk[15:0];
        last = rl ? 2*n + 8 : 2*n + 1;
        for (int i = 0; i < 16; i++) snap[i] = dmem[8'(m_src + 32'(i))];
        sent = dmem[8'(m_dst + 32'(n))];
        @(negedge clk);
        start_i = 1'b1;
        for (int t = 1; t <= last; t++) begin
            bit e_rd, e_wr, e_dn, e_bz, e_pr;
            @(negedge clk);
            if (t == 1) start_i = 1'b0;
            e_rd = (t <= 2*n) && (t % 2 == 1);
            e_wr = (t <= 2*n) && (t % 2 == 0);
            e_dn = (t == 2*n + 1);
            e_bz = (t <= 2*n) || (rl && t < 2*n + 8);
            e_pr = rl && (t >= 2*n + 1) && (t <= 2*n + 6);
            chk(mem_rd_en_o == e_rd, "R2", "read strobe", 32'(mem_rd_en_o), 32'(e_rd));
            chk(mem_wr_en_o == e_wr, "R2", "write strobe", 32'(mem_wr_en_o), 32'(e_wr));
            if (e_rd)
                chk(mem_rd_addr_o == m_src + 32'((t-1)/2), "R2", "read address",
                    mem_rd_addr_o, m_src + 32'((t-1)/2));
            if (e_wr) begin
                chk(mem_wr_addr_o == m_dst + 32'(t/2-1), "R2", "write address",
                    mem_wr_addr_o, m_dst + 32'(t/2-1));
                chk(mem_wr_data_o == snap[t/2-1], "R2", "write data",
                    32'(mem_wr_data_o), 32'(snap[t/2-1]));
            end
            chk(done_o == e_dn, (n == 0) ? "R9" : "R4", "done pulse", 32'(done_o), 32'(e_dn));
            if (e_dn) chk(done_opt_o == m_opt, "R4", "done options", done_opt_o, m_opt);
            chk(busy_o == e_bz, rl ? "R5" : "R6", "busy", 32'(busy_o), 32'(e_bz));
            chk(prm_rd_en_o == e_pr, rl ? "R5" : "R6", "param read strobe",
                32'(prm_rd_en_o), 32'(e_pr));
            if (e_pr)
                chk(prm_addr_o == lnk + 16'(t - 2*n - 1), "R5", "param address",
                    32'(prm_addr_o), 32'(lnk + 16'(t - 2*n - 1)));
            if (poke && t == 3) begin
                start_i = 1'b1; cfg_we_i = 1'b1; cfg_sel_i = 3'd2; cfg_wdata_i = 32'd9;
            end
            if (poke && t == 4) begin
                start_i = 1'b0; cfg_we_i = 1'b0;
            end
        end
        for (int i = 0; i < n; i++)
            chk(dmem[8'(m_dst + 32'(i))] == snap[i], "R3", "destination word",
                32'(dmem[8'(m_dst + 32'(i))]), 32'(snap[i]));
        chk(dmem[8'(m_dst + 32'(n))] == sent, "R3", "word past block untouched",
            32'(dmem[8'(m_dst + 32'(n))]), 32'(sent));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!(mem_rd_en_o || mem_wr_en_o || prm_rd_en_o || busy_o || done_o), "R10",
                "quiet after finish",
                {27'd0, mem_rd_en_o, mem_wr_en_o, prm_rd_en_o, busy_o, done_o}, 32'd0);
        end
        if (rl) begin
            m_opt = pram[6'(lnk)];     m_src = pram[6'(lnk + 16'd1)];
            m_cnt = pram[6'(lnk + 16'd2)]; m_dst = pram[6'(lnk + 16'd3)];
            m_idx = pram[6'(lnk + 16'd4)]; m_rlk = pram[6'(lnk + 16'd5)];
        end else begin
            m_src = m_src + 32'(n); m_dst = m_dst + 32'(n); m_cnt = 32'd0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd1234);
        rst = 1'b1; start_i = 1'b0; cfg_we_i = 1'b0; cfg_sel_i = '0; cfg_wdata_i = '0;
        for (int i = 0; i < 256; i++) dmem[i] = 16'($urandom);
        for (int i = 0; i < 64; i++) pram[i] = $urandom;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!busy_o, "R1", "busy after reset", 32'(busy_o), 0);
        chk(!done_o, "R1", "done after reset", 32'(done_o), 0);
        chk(!(mem_rd_en_o || mem_wr_en_o || prm_rd_en_o), "R1", "strobes after reset",
            {29'd0, mem_rd_en_o, mem_wr_en_o, prm_rd_en_o}, 0);
        rst = 1'b0;

        // R11 R6: plain transfer, link bit clear so link field 8 is ignored
        cfg_all(32'h0000_0000, 32'd10, 32'd5, 32'd140, 32'd1, 32'h0003_0008);
        run(1'b0);
        // R3: only the count is rewritten, addresses continue from 15 / 145
        cfg(3'd2, 32'd3); m_cnt = 32'd3;
        run(1'b0);
        // R9: count is now zero, start completes at once
        run(1'b0);

        // R5: linked set at 8; set 8 itself ends with link 16'hFFFF (R6)
        put_set(8, 32'h0000_A0F2, 32'd30, 32'd4, 32'd170, 32'd1, 32'h0002_FFFF);
        cfg_all(32'h0000_0012, 32'd50, 32'd3, 32'd200, 32'd1, 32'h0000_0008);
        run(1'b0);
        chk(m_src == 32'd30, "R5", "model took reloaded source", m_src, 32'd30);
        run(1'b0);

        // R9 with reload
        cfg_all(32'h0000_0002, 32'd0, 32'd0, 32'd128, 32'd1, 32'h0000_0008);
        run(1'b0);

        // R7: self-linked set repeats identically
        put_set(20, 32'h0000_0302, 32'd60, 32'd3, 32'd210, 32'd1, 32'h0003_0014);
        cfg_all(32'h0000_0302, 32'd60, 32'd3, 32'd210, 32'd1, 32'h0003_0014);
        for (int k = 0; k < 3; k++) begin
            run(1'b0);
            chk(m_src == 32'd60 && m_cnt == 32'd3, "R7", "self reload restored set",
                m_src, 32'd60);
        end

        // R8: restart and count write during busy are ignored
        cfg_all(32'h0000_0000, 32'd5, 32'd4, 32'd150, 32'd1, 32'h0000_FFFF);
        run(1'b1);
        run(1'b0);  // count stayed zero, so this completes at once

        // random mix
        for (int r = 0; r < 30; r++) begin
            logic [31:0] o, rr;
            int          base;
            base = (r % 2 == 0) ? 40 : 48;
            put_set(base, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
            o  = $urandom;
            o[1] = ($urandom_range(0, 1) == 1);
            rr = {16'($urandom), (($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'(base))};
            cfg_all(o, 32'($urandom_range(0, 100)), 32'($urandom_range(0, 12)),
                    32'($urandom_range(128, 230)), 32'd1, rr);
            run(1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule